// File: doc/BRIEF.md
# Logical-Lease Timestamp Coherence Directory

This block is the shared last-level directory of a small multicore that keeps its private caches coherent through logical time instead of invalidation messages. Each tracked line holds a state (shared, or modified with a single owning core), its data, a write timestamp `wts` marking the logical time the current version was created, and a read timestamp `rts` that closes the window of logical time over which that version may be read. Cores present requests stamped with their program timestamp `pts`, the logical time of their last memory operation. The directory returns the line's data, its `wts` and `rts`, and the requester's new `pts`.

A read reserves a lease by stretching `rts` forward. A write never waits for readers and never tells them anything. It jumps its new version to a logical time just past every lease already granted, so stale copies in other caches stay correct at earlier logical times. When a line is modified in another core's cache, the directory recalls it from that owner over a separate write-back channel. The owner returns its data and read timestamp and falls back to shared. Only then is the waiting request served. Requests are handled strictly one at a time, and the request channel is held off with a ready/valid handshake while a request or a recall is in progress.

Top module: `lease_dir`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `wb_valid` are 0, and every line is shared with data 0, `wts` 0 and `rts` 0.
- R2: A load (`req_op` 2'b00) on a shared line leaves data and `wts` unchanged, sets `rts` to max(`rts`, `pts` + LEASE) with LEASE defaulting to 10, and responds with the new `rts` and `rsp_pts` = max(`pts`, `wts`).
- R3: A store (`req_op` 2'b01) computes `ts` = max(`pts`, `rts` + 1), writes the store data with `wts` = `rts` = `ts`, makes the line modified and owned by the requester, issues no write-back, and responds with the stored data, `wts` = `rts` = `rsp_pts` = `ts`.
- R4: A load or store to a line modified by a different core raises `wb_valid` with `wb_core` = that owner and `wb_line` = the line, holds them unchanged until `wb_ack`, and keeps `req_ready` low throughout.
- R5: On `wb_ack` the line takes `wb_data` as its data, sets `rts` to max(`rts`, `wb_rts`), keeps `wts`, becomes shared, and the waiting load or store then completes by the rule of R2 or R3.
- R6: A load or store by the line's own owner raises no write-back; a load from the owner returns the line unchanged with `rsp_pts` = max(`pts`, `wts`), and a store follows R3.
- R7: A release (`req_op` 2'b10) from the owner of a modified line makes it shared with data `req_wdata` and `rts` = max(`rts`, `pts`). A release from any other core or on a shared line, and any request with `req_op` 2'b11, changes nothing. All three answer with the line's contents and `rsp_pts` = `pts`.
- R8: `rsp_valid` is a one-cycle pulse. With no recall it rises two clock edges after the accepting edge, and with a recall it rises two edges after the edge that takes `wb_ack`. `req_ready` stays low from the accepting edge until the response is presented.
- R9: A line's `rts` never decreases, and every response has `rsp_wts` <= `rsp_rts`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_core | input | CORE_W | Requesting core |
| req_op | input | 2 | 00 load, 01 store, 10 release, 11 no operation |
| req_line | input | LINE_W | Line index |
| req_pts | input | TS_W | Requester program timestamp |
| req_wdata | input | DATA_W | Store or release data |
| rsp_valid | output | 1 | Response pulse |
| rsp_core | output | CORE_W | Core the response is for |
| rsp_data | output | DATA_W | Line data |
| rsp_wts | output | TS_W | Version write timestamp |
| rsp_rts | output | TS_W | Lease end timestamp |
| rsp_pts | output | TS_W | Requester's new program timestamp |
| wb_valid | output | 1 | Recall request to an owner |
| wb_core | output | CORE_W | Owner being recalled |
| wb_line | output | LINE_W | Line being recalled |
| wb_ack | input | 1 | Owner returns the line |
| wb_data | input | DATA_W | Owner's data |
| wb_rts | input | TS_W | Owner's read timestamp |

## Verification
A directed sequence first rebuilds a two-core scenario: a store at a fresh line, a lease taken on another line, a store that must jump past that lease, and a load that recalls a modified line and extends its lease. Together these separate the store rule's two branches and show a recall merging the owner's read timestamp. Random traffic from four cores then mixes loads, stores, releases and no-operation codes on four lines with small, irregular program timestamps. That mix reaches the cases where `pts` + LEASE falls below an existing lease, where a store's `pts` is above or below `rts` + 1, and where a recall answer is delayed by several cycles. Releases from non-owners and the unused code are followed by loads that show the line unchanged.

// File: rtl/lease_dir_pkg.sv
package lease_dir_pkg;

    typedef enum logic [1:0] {
        OP_LOAD    = 2'b00,
        OP_STORE   = 2'b01,
        OP_RELEASE = 2'b10,
        OP_NONE    = 2'b11
    } dir_op_e;

    typedef enum logic {
        LN_SHARED = 1'b0,
        LN_MOD    = 1'b1
    } line_st_e;

    typedef enum logic [1:0] {
        FSM_IDLE   = 2'b00,
        FSM_RECALL = 2'b01,
        FSM_EXEC   = 2'b10
    } dir_fsm_e;

endpackage

// File: rtl/lease_dir_lines.sv
module lease_dir_lines
    import lease_dir_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int LINE_W    = 2,
    parameter int CORE_W    = 2,
    parameter int TS_W      = 16,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_idx,
    output line_st_e          rd_st,
    output logic [CORE_W-1:0] rd_owner,
    output logic [DATA_W-1:0] rd_data,
    output logic [TS_W-1:0]   rd_wts,
    output logic [TS_W-1:0]   rd_rts,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_idx,
    input  line_st_e          wr_st,
    input  logic [CORE_W-1:0] wr_owner,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TS_W-1:0]   wr_wts,
    input  logic [TS_W-1:0]   wr_rts
);

    typedef struct packed {
        line_st_e          st;
        logic [CORE_W-1:0] owner;
        logic [DATA_W-1:0] data;
        logic [TS_W-1:0]   wts;
        logic [TS_W-1:0]   rts;
    } entry_t;

    entry_t ent_d [NUM_LINES];
    entry_t ent_q [NUM_LINES];
    entry_t wr_ent;
    entry_t rd_ent;

    always_comb begin
        wr_ent = '{st: wr_st, owner: wr_owner, data: wr_data, wts: wr_wts, rts: wr_rts};
        for (int i = 0; i < NUM_LINES; i++) begin
            ent_d[i] = ent_q[i];
            if (wr_en && (wr_idx == LINE_W'(i))) begin
                ent_d[i] = wr_ent;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_LINES; i++) begin
            if (!rst_n) begin
                ent_q[i] <= '{st: LN_SHARED, owner: '0, data: '0, wts: '0, rts: '0};
            end else begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    always_comb begin
        rd_ent = '{st: LN_SHARED, owner: '0, data: '0, wts: '0, rts: '0};
        for (int i = 0; i < NUM_LINES; i++) begin
            if (rd_idx == LINE_W'(i)) begin
                rd_ent = ent_q[i];
            end
        end
        rd_st    = rd_ent.st;
        rd_owner = rd_ent.owner;
        rd_data  = rd_ent.data;
        rd_wts   = rd_ent.wts;
        rd_rts   = rd_ent.rts;
    end

endmodule

// File: rtl/lease_dir_calc.sv
module lease_dir_calc
    import lease_dir_pkg::*;
#(
    parameter int CORE_W = 2,
    parameter int TS_W   = 16,
    parameter int DATA_W = 32,
    parameter int LEASE  = 10
) (
    input  dir_op_e           op,
    input  logic [CORE_W-1:0] core,
    input  logic [TS_W-1:0]   pts,
    input  logic [DATA_W-1:0] wdata,
    input  line_st_e          cur_st,
    input  logic [CORE_W-1:0] cur_owner,
    input  logic [DATA_W-1:0] cur_data,
    input  logic [TS_W-1:0]   cur_wts,
    input  logic [TS_W-1:0]   cur_rts,
    output line_st_e          nxt_st,
    output logic [CORE_W-1:0] nxt_owner,
    output logic [DATA_W-1:0] nxt_data,
    output logic [TS_W-1:0]   nxt_wts,
    output logic [TS_W-1:0]   nxt_rts,
    output logic [DATA_W-1:0] out_data,
    output logic [TS_W-1:0]   out_wts,
    output logic [TS_W-1:0]   out_rts,
    output logic [TS_W-1:0]   out_pts
);

    localparam logic [TS_W-1:0] LEASE_TS = TS_W'(LEASE);

    function automatic logic [TS_W-1:0] ts_max(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    logic            is_owner;
    logic [TS_W-1:0] lease_end;
    logic [TS_W-1:0] past_lease;
    logic [TS_W-1:0] store_ts;
    logic [TS_W-1:0] read_pts;

    always_comb begin
        is_owner   = (cur_st == LN_MOD) && (cur_owner == core);
        lease_end  = pts + LEASE_TS;
        past_lease = cur_rts + TS_W'(1);
        store_ts   = ts_max(pts, past_lease);
        read_pts   = ts_max(pts, cur_wts);

        nxt_st    = cur_st;
        nxt_owner = cur_owner;
        nxt_data  = cur_data;
        nxt_wts   = cur_wts;
        nxt_rts   = cur_rts;
        out_pts   = pts;

        unique case (op)
            OP_LOAD: begin
                if (!is_owner) begin
                    nxt_rts = ts_max(cur_rts, lease_end);
                end
                out_pts = read_pts;
            end
            OP_STORE: begin
                nxt_st    = LN_MOD;
                nxt_owner = core;
                nxt_data  = wdata;
                nxt_wts   = store_ts;
                nxt_rts   = store_ts;
                out_pts   = store_ts;
            end
            OP_RELEASE: begin
                if (is_owner) begin
                    nxt_st   = LN_SHARED;
                    nxt_data = wdata;
                    nxt_rts  = ts_max(cur_rts, pts);
                end
            end
            default: begin
            end
        endcase

        out_data = nxt_data;
        out_wts  = nxt_wts;
        out_rts  = nxt_rts;
    end

endmodule

// File: rtl/lease_dir.sv
module lease_dir
    import lease_dir_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_LINES = 4,
    parameter int TS_W      = 16,
    parameter int DATA_W    = 32,
    parameter int LEASE     = 10,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CORE_W-1:0] req_core,
    input  logic [1:0]        req_op,
    input  logic [LINE_W-1:0] req_line,
    input  logic [TS_W-1:0]   req_pts,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [CORE_W-1:0] rsp_core,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TS_W-1:0]   rsp_wts,
    output logic [TS_W-1:0]   rsp_rts,
    output logic [TS_W-1:0]   rsp_pts,
    output logic              wb_valid,
    output logic [CORE_W-1:0] wb_core,
    output logic [LINE_W-1:0] wb_line,
    input  logic              wb_ack,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [TS_W-1:0]   wb_rts
);

    typedef struct packed {
        dir_fsm_e          fsm;
        logic [CORE_W-1:0] core;
        dir_op_e           op;
        logic [LINE_W-1:0] line;
        logic [TS_W-1:0]   pts;
        logic [DATA_W-1:0] wdata;
        logic              rsp_v;
        logic [CORE_W-1:0] rsp_core;
        logic [DATA_W-1:0] rsp_data;
        logic [TS_W-1:0]   rsp_wts;
        logic [TS_W-1:0]   rsp_rts;
        logic [TS_W-1:0]   rsp_pts;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LINE_W-1:0] rd_idx;
    line_st_e          rd_st;
    logic [CORE_W-1:0] rd_owner;
    logic [DATA_W-1:0] rd_data;
    logic [TS_W-1:0]   rd_wts;
    logic [TS_W-1:0]   rd_rts;

    logic              wr_en;
    line_st_e          wr_st;
    logic [CORE_W-1:0] wr_owner;
    logic [DATA_W-1:0] wr_data;
    logic [TS_W-1:0]   wr_wts;
    logic [TS_W-1:0]   wr_rts;

    line_st_e          ex_st;
    logic [CORE_W-1:0] ex_owner;
    logic [DATA_W-1:0] ex_data;
    logic [TS_W-1:0]   ex_wts;
    logic [TS_W-1:0]   ex_rts;
    logic [DATA_W-1:0] ex_out_data;
    logic [TS_W-1:0]   ex_out_wts;
    logic [TS_W-1:0]   ex_out_rts;
    logic [TS_W-1:0]   ex_out_pts;

    logic              req_op_acc;
    logic              need_recall;
    logic [TS_W-1:0]   merged_rts;

    lease_dir_lines #(
        .NUM_LINES (NUM_LINES),
        .LINE_W    (LINE_W),
        .CORE_W    (CORE_W),
        .TS_W      (TS_W),
        .DATA_W    (DATA_W)
    ) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_st    (rd_st),
        .rd_owner (rd_owner),
        .rd_data  (rd_data),
        .rd_wts   (rd_wts),
        .rd_rts   (rd_rts),
        .wr_en    (wr_en),
        .wr_idx   (ctl_q.line),
        .wr_st    (wr_st),
        .wr_owner (wr_owner),
        .wr_data  (wr_data),
        .wr_wts   (wr_wts),
        .wr_rts   (wr_rts)
    );

    lease_dir_calc #(
        .CORE_W (CORE_W),
        .TS_W   (TS_W),
        .DATA_W (DATA_W),
        .LEASE  (LEASE)
    ) u_calc (
        .op        (ctl_q.op),
        .core      (ctl_q.core),
        .pts       (ctl_q.pts),
        .wdata     (ctl_q.wdata),
        .cur_st    (rd_st),
        .cur_owner (rd_owner),
        .cur_data  (rd_data),
        .cur_wts   (rd_wts),
        .cur_rts   (rd_rts),
        .nxt_st    (ex_st),
        .nxt_owner (ex_owner),
        .nxt_data  (ex_data),
        .nxt_wts   (ex_wts),
        .nxt_rts   (ex_rts),
        .out_data  (ex_out_data),
        .out_wts   (ex_out_wts),
        .out_rts   (ex_out_rts),
        .out_pts   (ex_out_pts)
    );

    always_comb begin
        rd_idx      = (ctl_q.fsm == FSM_IDLE) ? req_line : ctl_q.line;
        req_op_acc  = (dir_op_e'(req_op) == OP_LOAD) || (dir_op_e'(req_op) == OP_STORE);
        need_recall = req_op_acc && (rd_st == LN_MOD) && (rd_owner != req_core);
        merged_rts  = (wb_rts > rd_rts) ? wb_rts : rd_rts;

        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;

        wr_en    = 1'b0;
        wr_st    = ex_st;
        wr_owner = ex_owner;
        wr_data  = ex_data;
        wr_wts   = ex_wts;
        wr_rts   = ex_rts;

        unique case (ctl_q.fsm)
            FSM_IDLE: begin
                if (req_valid) begin
                    ctl_d.core  = req_core;
                    ctl_d.op    = dir_op_e'(req_op);
                    ctl_d.line  = req_line;
                    ctl_d.pts   = req_pts;
                    ctl_d.wdata = req_wdata;
                    ctl_d.fsm   = need_recall ? FSM_RECALL : FSM_EXEC;
                end
            end
            FSM_RECALL: begin
                if (wb_ack) begin
                    wr_en     = 1'b1;
                    wr_st     = LN_SHARED;
                    wr_owner  = rd_owner;
                    wr_data   = wb_data;
                    wr_wts    = rd_wts;
                    wr_rts    = merged_rts;
                    ctl_d.fsm = FSM_EXEC;
                end
            end
            FSM_EXEC: begin
                wr_en          = 1'b1;
                ctl_d.rsp_v    = 1'b1;
                ctl_d.rsp_core = ctl_q.core;
                ctl_d.rsp_data = ex_out_data;
                ctl_d.rsp_wts  = ex_out_wts;
                ctl_d.rsp_rts  = ex_out_rts;
                ctl_d.rsp_pts  = ex_out_pts;
                ctl_d.fsm      = FSM_IDLE;
            end
            default: begin
                ctl_d.fsm = FSM_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{fsm: FSM_IDLE, op: OP_LOAD, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.fsm == FSM_IDLE);
    assign wb_valid  = (ctl_q.fsm == FSM_RECALL);
    assign wb_core   = (ctl_q.fsm == FSM_RECALL) ? rd_owner : '0;
    assign wb_line   = ctl_q.line;
    assign rsp_valid = ctl_q.rsp_v;
    assign rsp_core  = ctl_q.rsp_core;
    assign rsp_data  = ctl_q.rsp_data;
    assign rsp_wts   = ctl_q.rsp_wts;
    assign rsp_rts   = ctl_q.rsp_rts;
    assign rsp_pts   = ctl_q.rsp_pts;

endmodule

// File: rtl/lease_dir_chk.sv
module lease_dir_chk #(
    parameter int CORE_W = 2,
    parameter int LINE_W = 2,
    parameter int TS_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [TS_W-1:0]   rsp_wts,
    input logic [TS_W-1:0]   rsp_rts,
    input logic              wb_valid,
    input logic              wb_ack,
    input logic [CORE_W-1:0] wb_core,
    input logic [LINE_W-1:0] wb_line
);

    a_r4_recall_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ack) |=> (wb_valid && $stable(wb_core) && $stable(wb_line)))
        else $error("R4 recall dropped or changed before ack");

    a_r4_recall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !req_ready)
        else $error("R4 request channel open during recall");

    a_r5_ack_ends_recall: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_ack) |=> !wb_valid)
        else $error("R5 recall still raised after ack");

    a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid)
        else $error("R8 response longer than one cycle");

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready)
        else $error("R8 ready not dropped after accept");

    a_r9_window_order: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_wts <= rsp_rts))
        else $error("R9 response wts above rts");

endmodule

bind lease_dir lease_dir_chk #(
    .CORE_W (CORE_W),
    .LINE_W (LINE_W),
    .TS_W   (TS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_wts   (rsp_wts),
    .rsp_rts   (rsp_rts),
    .wb_valid  (wb_valid),
    .wb_ack    (wb_ack),
    .wb_core   (wb_core),
    .wb_line   (wb_line)
);

// File: tb/tb_lease_dir.sv
module tb_lease_dir;

    localparam int NC = 4;
    localparam int NL = 4;
    localparam int TW = 16;
    localparam int DW = 32;
    localparam int LS = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_core = '0;
    logic [1:0]    req_op = '0;
    logic [1:0]    req_line = '0;
    logic [TW-1:0] req_pts = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_core;
    logic [DW-1:0] rsp_data;
    logic [TW-1:0] rsp_wts;
    logic [TW-1:0] rsp_rts;
    logic [TW-1:0] rsp_pts;
    logic          wb_valid;
    logic [1:0]    wb_core;
    logic [1:0]    wb_line;
    logic          wb_ack = 1'b0;
    logic [DW-1:0] wb_data = '0;
    logic [TW-1:0] wb_rts = '0;

    int n_tests = 0;
    int n_fail  = 0;

    // bench-side line image
    bit            m_mod  [NL];
    int            m_own  [NL];
    logic [DW-1:0] m_data [NL];
    logic [TW-1:0] m_wts  [NL];
    logic [TW-1:0] m_rts  [NL];
    logic [TW-1:0] c_pts  [NC];

    always #4 clk = ~clk;

    lease_dir #(
        .NUM_CORES (NC),
        .NUM_LINES (NL),
        .TS_W      (TW),
        .DATA_W    (DW),
        .LEASE     (LS)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_core  (req_core),
        .req_op    (req_op),
        .req_line  (req_line),
        .req_pts   (req_pts),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_core  (rsp_core),
        .rsp_data  (rsp_data),
        .rsp_wts   (rsp_wts),
        .rsp_rts   (rsp_rts),
        .rsp_pts   (rsp_pts),
        .wb_valid  (wb_valid),
        .wb_core   (wb_core),
        .wb_line   (wb_line),
        .wb_ack    (wb_ack),
        .wb_data   (wb_data),
        .wb_rts    (wb_rts)
    );

    function automatic logic [TW-1:0] tmax(input logic [TW-1:0] a, input logic [TW-1:0] b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Issue one request, serve any recall after ack_dly cycles, check everything.
    task automatic do_req(input int c, input int op, input int ln, input logic [TW-1:0] pts,
                          input logic [DW-1:0] wd, input int ack_dly,
                          input logic [DW-1:0] own_data, input logic [TW-1:0] own_rts);
        bit            owner_hit, recall_exp, saw_wb, done;
        int            waited, wb_cnt;
        string         tag;
        logic [TW-1:0] old_rts, ts;
        logic [DW-1:0] e_data;
        logic [TW-1:0] e_wts, e_rts, e_pts;

        owner_hit  = m_mod[ln] && (m_own[ln] == c);
        recall_exp = m_mod[ln] && (m_own[ln] != c) && (op < 2);
        if (recall_exp) tag = "R5";
        else if (owner_hit && op < 2) tag = "R6";
        else if (op == 0) tag = "R2";
        else if (op == 1) tag = "R3";
        else tag = "R7";

        req_core  = 2'(c);
        req_op    = 2'(op);
        req_line  = 2'(ln);
        req_pts   = pts;
        req_wdata = wd;
        req_valid = 1'b1;
        @(posedge clk);
        waited = 0; wb_cnt = 0; saw_wb = 0; done = 0;
        while (!done) begin
            @(negedge clk);
            req_valid = 1'b0;
            wb_ack    = 1'b0;
            waited++;
            if (rsp_valid) begin
                done = 1;
            end else if (wb_valid) begin
                if (!saw_wb) begin
                    // R4: owner and line named in the recall
                    check(wb_core == 2'(m_own[ln]), "R4", "wb_core", wb_core, m_own[ln]);
                    check(wb_line == 2'(ln), "R4", "wb_line", wb_line, ln);
                end
                saw_wb = 1;
                check(!req_ready, "R4", "req_ready during recall", req_ready, 0);
                if (wb_cnt == ack_dly) begin
                    wb_ack  = 1'b1;
                    wb_data = own_data;
                    wb_rts  = own_rts;
                end
                wb_cnt++;
            end else if (waited > 20) begin
                check(0, "R8", "response never arrived", waited, 0);
                done = 1;
            end
        end
        check(saw_wb == recall_exp, recall_exp ? "R4" : "R3",
              "recall raised", saw_wb, recall_exp);
        check(waited == (recall_exp ? 3 + ack_dly : 2), "R8", "response latency",
              waited, recall_exp ? 3 + ack_dly : 2);
        check(req_ready, "R8", "ready with response", req_ready, 1);

        // bench model of the line update
        if (recall_exp) begin
            m_mod[ln]  = 0;
            m_data[ln] = own_data;
            m_rts[ln]  = tmax(m_rts[ln], own_rts);
        end
        old_rts = m_rts[ln];
        e_pts   = pts;
        case (op)
            0: begin
                if (!(m_mod[ln] && m_own[ln] == c)) m_rts[ln] = tmax(m_rts[ln], pts + TW'(LS));
                e_pts = tmax(pts, m_wts[ln]);
            end
            1: begin
                ts = tmax(pts, m_rts[ln] + TW'(1));
                m_mod[ln] = 1; m_own[ln] = c; m_data[ln] = wd;
                m_wts[ln] = ts; m_rts[ln] = ts; e_pts = ts;
            end
            2: begin
                if (m_mod[ln] && m_own[ln] == c) begin
                    m_mod[ln] = 0; m_data[ln] = wd; m_rts[ln] = tmax(m_rts[ln], pts);
                end
            end
            default: begin end
        endcase
        e_data = m_data[ln]; e_wts = m_wts[ln]; e_rts = m_rts[ln];

        check(rsp_core == 2'(c), tag, "rsp_core", rsp_core, c);
        check(rsp_data == e_data, tag, "rsp_data", rsp_data, e_data);
        check(rsp_wts == e_wts, tag, "rsp_wts", rsp_wts, e_wts);
        check(rsp_rts == e_rts, tag, "rsp_rts", rsp_rts, e_rts);
        check(rsp_pts == e_pts, tag, "rsp_pts", rsp_pts, e_pts);
        check(rsp_rts >= old_rts && rsp_wts <= rsp_rts, "R9", "lease order", rsp_rts, old_rts);
        c_pts[c] = rsp_pts;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R8", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NL; i++) begin
            m_mod[i] = 0; m_own[i] = 0; m_data[i] = '0; m_wts[i] = '0; m_rts[i] = '0;
        end
        for (int i = 0; i < NC; i++) c_pts[i] = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        check(wb_valid == 1'b0, "R1", "wb_valid", wb_valid, 0);
        // R1: fresh line reads back zero data and zero wts, lease 5+10
        do_req(2, 0, 3, 16'd5, 32'h0, 0, 32'h0, 16'd0);
        check(rsp_rts == 16'd15 && rsp_data == 0, "R1", "fresh line lease", rsp_rts, 15);

        // Directed two-core walk (line 0 = A, line 1 = B)
        do_req(0, 1, 0, 16'd0, 32'hA1, 0, 32'h0, 16'd0);       // R3 store -> ts 1
        check(rsp_wts == 16'd1, "R3", "store past empty lease", rsp_wts, 1);
        do_req(0, 0, 1, 16'd1, 32'h0, 0, 32'h0, 16'd0);        // R2 load -> rts 11
        check(rsp_rts == 16'd11, "R2", "lease at pts+10", rsp_rts, 11);
        do_req(1, 1, 1, 16'd0, 32'hB2, 0, 32'h0, 16'd0);       // R3 jump -> 12
        check(rsp_pts == 16'd12, "R3", "store jumps past lease", rsp_pts, 12);
        do_req(1, 0, 0, 16'd12, 32'h0, 2, 32'hA1, 16'd1);      // R5 recall -> rts 22
        check(rsp_rts == 16'd22, "R5", "lease after recall", rsp_rts, 22);
        do_req(1, 0, 1, 16'd12, 32'h0, 0, 32'h0, 16'd0);       // R6 owner load
        do_req(1, 1, 1, 16'd3, 32'hB3, 0, 32'h0, 16'd0);       // R6 owner store -> 13
        do_req(2, 2, 1, 16'd40, 32'hDEAD, 0, 32'h0, 16'd0);    // R7 non-owner release ignored
        do_req(3, 3, 1, 16'd50, 32'hBEEF, 0, 32'h0, 16'd0);    // R7 code 11 ignored
        do_req(1, 2, 1, 16'd30, 32'hB4, 0, 32'h0, 16'd0);      // R7 owner release
        do_req(2, 0, 1, 16'd2, 32'h0, 0, 32'h0, 16'd0);        // R2 lease not lowered
        check(rsp_data == 32'hB4 && rsp_rts == 16'd30, "R7", "release data and rts",
              rsp_rts, 30);

        // Random traffic
        for (int k = 0; k < 400; k++) begin
            int c, op, ln, r, dly;
            logic [TW-1:0] p;
            c  = int'($urandom % NC);
            ln = int'($urandom % NL);
            r  = int'($urandom % 100);
            if (r < 45) op = 0;
            else if (r < 80) op = 1;
            else if (r < 92) op = 2;
            else op = 3;
            if (op == 2 && m_mod[ln] && ($urandom % 2 == 0)) c = m_own[ln];
            p = c_pts[c] + TW'($urandom % 4);
            if ($urandom % 8 == 0) p = TW'($urandom % 64);
            dly = int'($urandom % 4);
            do_req(c, op, ln, p, $urandom, dly, $urandom, m_wts[ln] + TW'($urandom % 8));
        end

        finish_run();
    end

endmodule